// File: doc/BRIEF.md
# Mailbox Command Engine

This block runs one command transaction on behalf of a host requester against a co-processor that shares a mailbox register window with it. A requester hands over a command code, how many argument words to send, how many result words to fetch back, and up to four argument words. The engine then drives a simple register-bus master through the full exchange. It waits until the co-processor's command register reads idle and clears the status word. It loads the arguments and the command, then rings a doorbell in a separate interrupt-set window. It waits for completion, collects the result words and releases the mailbox.

Completion is detected in one of two ways, selected by a static input. In the first, a rising edge on a completion interrupt line prompts one read of the status word. In the second, the status word is read at a fixed cycle period until it becomes nonzero. A cycle-count timeout bounds both. The status value is turned into a small result code that is returned together with the result words in a single-cycle done pulse. Only one command is in flight at a time; the requester may offer a new request whenever the engine is ready.

Top module: `mbx_cmd_engine`

## Requirements
- R1: `req_ready` is high only while the engine is idle, a request is taken when `req_valid` and `req_ready` are both high, and every accepted request ends in exactly one single-cycle `done_valid` pulse carrying `done_code` (0 ok, 1 busy, 2 timeout, 3 invalid command, 4 unsupported, 5 no map, 6 map already set, 7 failure) and `done_args` (word k in bits 32k+31..32k, zero where no word was read).
- R2: Before any write, the command register (mailbox offset 0x00) is read until it returns zero; if `IDLE_READS` consecutive reads all return nonzero, the request ends with code 1 and no bus write at all.
- R3: After the idle check, the bus writes are, in order: 0 to the status word (mailbox offset 0x04), the input arguments in ascending index order to mailbox offset 0x18 + 4*slot, the command code to offset 0x00, and a word with bit 31 set to offset 0x04 of the doorbell window (`bus_win` = 1).
- R4: An argument index of 4 or more uses slot 0 (offset 0x18) for both writes and reads; its write data is argument word 0 and its read data lands in result word 0, so no mailbox access falls outside offsets 0x00, 0x04 and 0x18..0x24.
- R5: With `irq_mode` = 1, a rising edge on `cmpl_irq` seen after the command write causes one read of the status word, whose value is then judged.
- R6: With `irq_mode` = 0, the status word is read when the wait begins and again every `POLL_CYCLES` cycles until a read returns nonzero; `cmpl_irq` is not used.
- R7: If no completion is seen within `TIMEOUT_CYCLES` cycles of the wait beginning, the request ends with code 2, between `TIMEOUT_CYCLES` and `TIMEOUT_CYCLES`+8 cycles after the doorbell write, with no write after the doorbell.
- R8: A status value of 0 or above 0xFF ends the request with code 2, with no result reads and no release write.
- R9: An accepted status maps to a code: 0xF0 to 0, 0xF1 to 3, 0xF2 to 4, 0xF3 to 5, 0xF4 to 6, 0xFF to 7, and any other value from 0x01 to 0xFF to 0.
- R10: After an accepted status, the requested number of result words is read from the argument slots in ascending index order, then 0 is written to the status word, and then the done pulse is given.
- R11: A bus access holds `bus_req` and its address, direction, window and write data steady until `bus_ack`, and the engine makes no bus access while idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_mode | input | 1 | 1: completion by interrupt edge, 0: completion by status polling |
| cmpl_irq | input | 1 | Completion interrupt line from the co-processor |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine idle, request may be taken |
| req_cmd | input | CMD_W | Command code |
| req_nin | input | CNT_W | Number of argument words to write |
| req_nout | input | CNT_W | Number of result words to read |
| req_args | input | NARGS*DATA_W | Argument words, word k in bits 32k+31..32k |
| done_valid | output | 1 | One-cycle completion pulse |
| done_code | output | 3 | Result code |
| done_args | output | NARGS*DATA_W | Result words |
| bus_req | output | 1 | Bus access request |
| bus_wr | output | 1 | 1 write, 0 read |
| bus_win | output | 1 | 0 mailbox window, 1 doorbell window |
| bus_addr | output | ADDR_W | Byte offset within the window |
| bus_wdata | output | DATA_W | Write data |
| bus_rdata | input | DATA_W | Read data, valid with bus_ack |
| bus_ack | input | 1 | Access complete |

## Verification
The bench sweeps the input and output word counts from 0 to 6 so that indices past the last slot are exercised; an engine that forgot to fold them back would write past offset 0x24 or land a result in the wrong word. It walks the whole status table plus the 0 and 0x100 cases, where a careless design would hand back success or go on to release the mailbox after a bad status. The idle check is run with exactly one read fewer than the limit and with the limit reached, which catches an off-by-one retry counter and any write leaking out of an aborted request. Both completion methods are run to the timeout, and the moment of the done pulse is checked against a window so a timer that never expires or fires early is caught.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

   localparam int unsigned RES_W = 3;

   typedef enum logic [RES_W-1:0] {
      RES_OK      = 3'd0,
      RES_BUSY    = 3'd1,
      RES_TIMEOUT = 3'd2,
      RES_INVALID = 3'd3,
      RES_UNSUPP  = 3'd4,
      RES_NOMAP   = 3'd5,
      RES_MAPSET  = 3'd6,
      RES_FAIL    = 3'd7
   } result_e;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_CHKIDLE,
      ST_CLRST,
      ST_ARGS,
      ST_CMD,
      ST_BELL,
      ST_WAIT,
      ST_STAT,
      ST_OUTS,
      ST_RELEASE
   } eng_state_e;

endpackage

// File: rtl/mbx_slot_map.sv
module mbx_slot_map #(
   parameter int unsigned NARGS    = 4,
   parameter int unsigned CNT_W    = 3,
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned ARG_BASE = 24,
   parameter int unsigned STRIDE   = 4
) (
   input  logic [CNT_W-1:0]                            idx,
   output logic [((NARGS > 1) ? $clog2(NARGS) : 1)-1:0] slot,
   output logic [ADDR_W-1:0]                           addr
);
   localparam int unsigned SLOT_W = (NARGS > 1) ? $clog2(NARGS) : 1;

   logic in_range;

   assign in_range = (idx < CNT_W'(NARGS));

   // Out-of-range indices fold back onto the first slot.
   assign slot = in_range ? idx[SLOT_W-1:0] : '0;
   assign addr = ADDR_W'(ARG_BASE) + ADDR_W'(slot) * ADDR_W'(STRIDE);

endmodule

// File: rtl/mbx_status_decode.sv
module mbx_status_decode
   import mbx_pkg::*;
#(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned STAT_MAX = 255
) (
   input  logic [DATA_W-1:0] status,
   output logic              bad,
   output result_e           code
);
   assign bad = (status == '0) || (status > DATA_W'(STAT_MAX));

   always_comb begin
      case (status[7:0])
         8'hF1:   code = RES_INVALID;
         8'hF2:   code = RES_UNSUPP;
         8'hF3:   code = RES_NOMAP;
         8'hF4:   code = RES_MAPSET;
         8'hFF:   code = RES_FAIL;
         default: code = RES_OK;
      endcase
   end

endmodule

// File: rtl/mbx_wait_timer.sv
module mbx_wait_timer #(
   parameter int unsigned LIMIT  = 15000000,
   parameter int unsigned PERIOD = 50000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic expired,
   output logic tick
);
   localparam int unsigned TW = $clog2(LIMIT + 1);

   logic [TW-1:0] t_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         t_q <= '0;
      end else if (!run) begin
         t_q <= '0;
      end else if (t_q != TW'(LIMIT)) begin
         t_q <= t_q + TW'(1);
      end
   end

   assign expired = run && (t_q == TW'(LIMIT));

   generate
      if (PERIOD <= 1) begin : g_tick_every
         assign tick = run;
      end else begin : g_tick_div
         localparam int unsigned PW = $clog2(PERIOD);
         logic [PW-1:0] p_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               p_q <= '0;
            end else if (!run || (p_q == PW'(PERIOD - 1))) begin
               p_q <= '0;
            end else begin
               p_q <= p_q + PW'(1);
            end
         end
         assign tick = run && (p_q == '0);
      end
   endgenerate

endmodule

// File: rtl/mbx_cmd_engine.sv
module mbx_cmd_engine
   import mbx_pkg::*;
#(
   parameter int unsigned DATA_W         = 32,
   parameter int unsigned ADDR_W         = 8,
   parameter int unsigned CMD_W          = 8,
   parameter int unsigned NARGS          = 4,
   parameter int unsigned CNT_W          = 3,
   parameter int unsigned IDLE_READS     = 10000,
   parameter int unsigned TIMEOUT_CYCLES = 15000000,
   parameter int unsigned POLL_CYCLES    = 50000,
   parameter int unsigned STAT_MAX       = 255,
   parameter int unsigned CMD_OFF        = 0,
   parameter int unsigned STAT_OFF       = 4,
   parameter int unsigned ARG_BASE       = 24,
   parameter int unsigned BELL_OFF       = 4,
   parameter int unsigned BELL_BIT       = 31
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    irq_mode,
   input  logic                    cmpl_irq,
   input  logic                    req_valid,
   output logic                    req_ready,
   input  logic [CMD_W-1:0]        req_cmd,
   input  logic [CNT_W-1:0]        req_nin,
   input  logic [CNT_W-1:0]        req_nout,
   input  logic [NARGS*DATA_W-1:0] req_args,
   output logic                    done_valid,
   output logic [RES_W-1:0]        done_code,
   output logic [NARGS*DATA_W-1:0] done_args,
   output logic                    bus_req,
   output logic                    bus_wr,
   output logic                    bus_win,
   output logic [ADDR_W-1:0]       bus_addr,
   output logic [DATA_W-1:0]       bus_wdata,
   input  logic [DATA_W-1:0]       bus_rdata,
   input  logic                    bus_ack
);
   localparam int unsigned SLOT_W = (NARGS > 1) ? $clog2(NARGS) : 1;
   localparam int unsigned ICW    = $clog2(IDLE_READS + 1);
   localparam int unsigned BYTES  = DATA_W / 8;

   generate
      if (CMD_W > DATA_W) begin : g_bad_cmd_w
         $error("CMD_W must not exceed DATA_W");
      end
      if ((NARGS < 2) || ((1 << SLOT_W) != NARGS)) begin : g_bad_nargs
         $error("NARGS must be a power of two of at least 2");
      end
      if (NARGS >= (1 << CNT_W)) begin : g_bad_cnt_w
         $error("CNT_W must count past NARGS");
      end
      if ((ARG_BASE + NARGS * BYTES) > (1 << ADDR_W)) begin : g_bad_addr_w
         $error("argument slots do not fit in ADDR_W");
      end
      if ((STAT_MAX > 255) || (BELL_BIT >= DATA_W)) begin : g_bad_stat
         $error("STAT_MAX or BELL_BIT out of range");
      end
      if ((IDLE_READS < 1) || (TIMEOUT_CYCLES < 1)) begin : g_bad_limits
         $error("IDLE_READS and TIMEOUT_CYCLES must be nonzero");
      end
   endgenerate

   eng_state_e        state_q;
   logic              bus_req_q;
   logic [CMD_W-1:0]  cmd_q;
   logic [CNT_W-1:0]  nin_q;
   logic [CNT_W-1:0]  nout_q;
   logic [DATA_W-1:0] args_q [NARGS];
   logic [DATA_W-1:0] outs_q [NARGS];
   logic [CNT_W-1:0]  idx_q;
   logic [ICW-1:0]    icnt_q;
   result_e           res_q;
   result_e           code_q;
   logic              done_q;
   logic              irq_prev_q;
   logic              seen_q;

   logic [SLOT_W-1:0] slot;
   logic [ADDR_W-1:0] slot_addr;
   logic              st_bad;
   result_e           st_code;
   logic              tmo_expired;
   logic              poll_tick;
   logic              waiting;

   mbx_slot_map #(
      .NARGS    (NARGS),
      .CNT_W    (CNT_W),
      .ADDR_W   (ADDR_W),
      .ARG_BASE (ARG_BASE),
      .STRIDE   (BYTES)
   ) u_slot (
      .idx  (idx_q),
      .slot (slot),
      .addr (slot_addr)
   );

   mbx_status_decode #(
      .DATA_W   (DATA_W),
      .STAT_MAX (STAT_MAX)
   ) u_dec (
      .status (bus_rdata),
      .bad    (st_bad),
      .code   (st_code)
   );

   assign waiting = (state_q == ST_WAIT);

   mbx_wait_timer #(
      .LIMIT  (TIMEOUT_CYCLES),
      .PERIOD (POLL_CYCLES)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (waiting),
      .expired (tmo_expired),
      .tick    (poll_tick)
   );

   // Bus fields follow the state; they stay put while a request is pending.
   always_comb begin
      bus_wr    = 1'b0;
      bus_win   = 1'b0;
      bus_addr  = ADDR_W'(STAT_OFF);
      bus_wdata = '0;
      case (state_q)
         ST_CHKIDLE: bus_addr = ADDR_W'(CMD_OFF);
         ST_CLRST: bus_wr = 1'b1;
         ST_ARGS: begin
            bus_wr    = 1'b1;
            bus_addr  = slot_addr;
            bus_wdata = args_q[slot];
         end
         ST_CMD: begin
            bus_wr    = 1'b1;
            bus_addr  = ADDR_W'(CMD_OFF);
            bus_wdata = DATA_W'(cmd_q);
         end
         ST_BELL: begin
            bus_wr    = 1'b1;
            bus_win   = 1'b1;
            bus_addr  = ADDR_W'(BELL_OFF);
            bus_wdata = DATA_W'(1) << BELL_BIT;
         end
         ST_OUTS: bus_addr = slot_addr;
         ST_RELEASE: bus_wr = 1'b1;
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         bus_req_q  <= 1'b0;
         cmd_q      <= '0;
         nin_q      <= '0;
         nout_q     <= '0;
         idx_q      <= '0;
         icnt_q     <= '0;
         res_q      <= RES_OK;
         code_q     <= RES_OK;
         done_q     <= 1'b0;
         irq_prev_q <= 1'b0;
         seen_q     <= 1'b0;
         for (int k = 0; k < NARGS; k++) begin
            args_q[k] <= '0;
            outs_q[k] <= '0;
         end
      end else begin
         done_q     <= 1'b0;
         irq_prev_q <= cmpl_irq;
         if (state_q == ST_CMD) begin
            seen_q <= 1'b0;
         end else if (cmpl_irq && !irq_prev_q) begin
            seen_q <= 1'b1;
         end

         case (state_q)
            ST_IDLE: begin
               if (req_valid) begin
                  cmd_q  <= req_cmd;
                  nin_q  <= req_nin;
                  nout_q <= req_nout;
                  idx_q  <= '0;
                  icnt_q <= '0;
                  for (int k = 0; k < NARGS; k++) begin
                     args_q[k] <= req_args[k*DATA_W +: DATA_W];
                     outs_q[k] <= '0;
                  end
                  state_q <= ST_CHKIDLE;
               end
            end

            ST_WAIT: begin
               if (irq_mode) begin
                  if (seen_q) begin
                     state_q <= ST_STAT;
                  end else if (tmo_expired) begin
                     done_q  <= 1'b1;
                     code_q  <= RES_TIMEOUT;
                     state_q <= ST_IDLE;
                  end
               end else if (bus_req_q) begin
                  if (bus_ack) begin
                     bus_req_q <= 1'b0;
                     if (bus_rdata != '0) begin
                        if (st_bad) begin
                           done_q  <= 1'b1;
                           code_q  <= RES_TIMEOUT;
                           state_q <= ST_IDLE;
                        end else begin
                           res_q   <= st_code;
                           idx_q   <= '0;
                           state_q <= (nout_q != '0) ? ST_OUTS : ST_RELEASE;
                        end
                     end
                  end
               end else if (tmo_expired) begin
                  done_q  <= 1'b1;
                  code_q  <= RES_TIMEOUT;
                  state_q <= ST_IDLE;
               end else if (poll_tick) begin
                  bus_req_q <= 1'b1;
               end
            end

            default: begin
               if (!bus_req_q) begin
                  bus_req_q <= 1'b1;
               end else if (bus_ack) begin
                  bus_req_q <= 1'b0;
                  case (state_q)
                     ST_CHKIDLE: begin
                        if (bus_rdata == '0) begin
                           state_q <= ST_CLRST;
                        end else if (icnt_q == ICW'(IDLE_READS - 1)) begin
                           done_q  <= 1'b1;
                           code_q  <= RES_BUSY;
                           state_q <= ST_IDLE;
                        end else begin
                           icnt_q <= icnt_q + ICW'(1);
                        end
                     end
                     ST_CLRST: begin
                        idx_q   <= '0;
                        state_q <= (nin_q != '0) ? ST_ARGS : ST_CMD;
                     end
                     ST_ARGS: begin
                        if (idx_q == nin_q - CNT_W'(1)) begin
                           state_q <= ST_CMD;
                        end else begin
                           idx_q <= idx_q + CNT_W'(1);
                        end
                     end
                     ST_CMD: state_q <= ST_BELL;
                     ST_BELL: state_q <= ST_WAIT;
                     ST_STAT: begin
                        if (st_bad) begin
                           done_q  <= 1'b1;
                           code_q  <= RES_TIMEOUT;
                           state_q <= ST_IDLE;
                        end else begin
                           res_q   <= st_code;
                           idx_q   <= '0;
                           state_q <= (nout_q != '0) ? ST_OUTS : ST_RELEASE;
                        end
                     end
                     ST_OUTS: begin
                        outs_q[slot] <= bus_rdata;
                        if (idx_q == nout_q - CNT_W'(1)) begin
                           state_q <= ST_RELEASE;
                        end else begin
                           idx_q <= idx_q + CNT_W'(1);
                        end
                     end
                     ST_RELEASE: begin
                        done_q  <= 1'b1;
                        code_q  <= res_q;
                        state_q <= ST_IDLE;
                     end
                     default: state_q <= ST_IDLE;
                  endcase
               end
            end
         endcase
      end
   end

   assign req_ready  = (state_q == ST_IDLE);
   assign bus_req    = bus_req_q;
   assign done_valid = done_q;
   assign done_code  = code_q;

   generate
      for (genvar g = 0; g < NARGS; g++) begin : g_out
         assign done_args[g*DATA_W +: DATA_W] = outs_q[g];
      end
   endgenerate

endmodule

// File: rtl/mbx_cmd_engine_chk.sv
module mbx_cmd_engine_chk #(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned NARGS    = 4,
   parameter int unsigned CMD_OFF  = 0,
   parameter int unsigned STAT_OFF = 4,
   parameter int unsigned ARG_BASE = 24,
   parameter int unsigned BELL_OFF = 4,
   parameter int unsigned BELL_BIT = 31
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              done_valid,
   input logic              bus_req,
   input logic              bus_wr,
   input logic              bus_win,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              bus_ack
);
   localparam logic [ADDR_W-1:0] ARG_LAST = ADDR_W'(ARG_BASE + (NARGS - 1) * (DATA_W / 8));

   // R1: a taken request makes the engine busy on the next cycle
   p_one_outstanding_r1: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready |=> !req_ready);

   // R1: completion is a single-cycle pulse
   p_done_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid |=> !done_valid);

   // R11: a pending access keeps all of its fields
   p_hold_until_ack_r11: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_wr)
                              && $stable(bus_win) && $stable(bus_wdata));

   // R11: no bus traffic while idle
   p_quiet_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !bus_req);

   // R4: mailbox accesses stay inside the known words
   p_in_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && !bus_win |-> (bus_addr == ADDR_W'(CMD_OFF)) || (bus_addr == ADDR_W'(STAT_OFF))
                              || ((bus_addr >= ADDR_W'(ARG_BASE)) && (bus_addr <= ARG_LAST)));

   // R3: the doorbell window only ever sees the ring word
   p_bell_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && bus_win |-> bus_wr && bus_wdata[BELL_BIT] && (bus_addr == ADDR_W'(BELL_OFF)));

endmodule

bind mbx_cmd_engine mbx_cmd_engine_chk #(
   .DATA_W   (DATA_W),
   .ADDR_W   (ADDR_W),
   .NARGS    (NARGS),
   .CMD_OFF  (CMD_OFF),
   .STAT_OFF (STAT_OFF),
   .ARG_BASE (ARG_BASE),
   .BELL_OFF (BELL_OFF),
   .BELL_BIT (BELL_BIT)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_ready  (req_ready),
   .done_valid (done_valid),
   .bus_req    (bus_req),
   .bus_wr     (bus_wr),
   .bus_win    (bus_win),
   .bus_addr   (bus_addr),
   .bus_wdata  (bus_wdata),
   .bus_ack    (bus_ack)
);

// File: tb/tb_mbx_cmd_engine.sv
`timescale 1ns/1ps
module tb_mbx_cmd_engine;
   localparam int IDLE_N = 8;
   localparam int TMO    = 200;
   localparam int POLL   = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         irq_mode_r = 1'b1;
   logic         cmpl_irq;
   logic         req_valid = 1'b0;
   logic         req_ready;
   logic [7:0]   req_cmd = '0;
   logic [2:0]   req_nin = '0;
   logic [2:0]   req_nout = '0;
   logic [127:0] req_args = '0;
   logic         done_valid;
   logic [2:0]   done_code;
   logic [127:0] done_args;
   logic         bus_req, bus_wr, bus_win, bus_ack;
   logic [7:0]   bus_addr;
   logic [31:0]  bus_wdata, bus_rdata;

   always #10 clk = ~clk;

   mbx_cmd_engine #(
      .IDLE_READS     (IDLE_N),
      .TIMEOUT_CYCLES (TMO),
      .POLL_CYCLES    (POLL)
   ) dut (
      .clk(clk), .rst_n(rst_n), .irq_mode(irq_mode_r), .cmpl_irq(cmpl_irq),
      .req_valid(req_valid), .req_ready(req_ready), .req_cmd(req_cmd),
      .req_nin(req_nin), .req_nout(req_nout), .req_args(req_args),
      .done_valid(done_valid), .done_code(done_code), .done_args(done_args),
      .bus_req(bus_req), .bus_wr(bus_wr), .bus_win(bus_win), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack)
   );

   // co-processor and mailbox model configuration
   int          cfg_busy = 0;
   int          cfg_delay = 5;
   bit          cfg_respond = 1'b1;
   logic [31:0] cfg_stat = 32'hF0;
   logic [31:0] cfg_out [4];

   logic [31:0] mem [16];
   int          cyc, cmd_rd, stat_rd, cp_cnt, wn, rn, bell_cyc;
   logic        wl_win [64];
   logic [7:0]  wl_addr [64];
   logic [31:0] wl_data [64];

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (!rst_n) begin
         bus_ack <= 1'b0; bus_rdata <= '0; cmpl_irq <= 1'b0;
         cp_cnt <= 0; wn <= 0; rn <= 0; cmd_rd <= 0; stat_rd <= 0; bell_cyc <= 0;
         for (int k = 0; k < 16; k++) mem[k] <= '0;
      end else begin
         if (req_valid && req_ready) begin
            wn <= 0; rn <= 0; cmd_rd <= 0; stat_rd <= 0; cp_cnt <= 0; cmpl_irq <= 1'b0;
         end
         bus_ack <= bus_req && !bus_ack;
         if (bus_req && !bus_ack) begin
            if (bus_wr) begin
               if (wn < 64) begin
                  wl_win[wn] <= bus_win; wl_addr[wn] <= bus_addr; wl_data[wn] <= bus_wdata;
               end
               wn <= wn + 1;
               if (!bus_win) mem[bus_addr[5:2]] <= bus_wdata;
               else if (bus_addr == 8'h04 && bus_wdata[31]) begin
                  cp_cnt <= cfg_delay; bell_cyc <= cyc;
               end
            end else begin
               rn <= rn + 1;
               if (bus_addr == 8'h00) begin
                  bus_rdata <= (cmd_rd < cfg_busy) ? 32'h1 : 32'h0;
                  cmd_rd <= cmd_rd + 1;
               end else begin
                  bus_rdata <= mem[bus_addr[5:2]];
                  if (bus_addr == 8'h04) stat_rd <= stat_rd + 1;
               end
            end
         end
         if (cp_cnt > 0) begin
            cp_cnt <= cp_cnt - 1;
            if (cp_cnt == 1 && cfg_respond) begin
               mem[1] <= cfg_stat;
               for (int k = 0; k < 4; k++) mem[6+k] <= cfg_out[k];
               cmpl_irq <= irq_mode_r;
            end
         end
      end
   end

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;
   logic [31:0] a [4];
   logic [2:0]  got_code;
   logic [127:0] got_args;
   int          done_cyc;

   task automatic chk(input bit ok, input string rq, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=0x%0h expected=0x%0h", rq, what, act, exp);
      end
   endtask

   task automatic run_cmd(input logic [7:0] cmd, input int nin, input int nout);
      @(negedge clk);
      req_cmd = cmd; req_nin = 3'(nin); req_nout = 3'(nout);
      for (int k = 0; k < 4; k++) req_args[k*32 +: 32] = a[k];
      req_valid = 1'b1;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      chk(!req_ready, "R1", "ready while busy", longint'(req_ready), 0);
      while (!done_valid) @(negedge clk);
      got_code = done_code; got_args = done_args; done_cyc = cyc;
      @(negedge clk);
      chk(!done_valid, "R1", "done pulse width", longint'(done_valid), 0);
   endtask

   // Compare the write log with the sequence the requirements give.
   task automatic check_writes(input logic [7:0] cmd, input int nin, input bit rel, input string rq);
      logic        ew [16];
      logic [7:0]  ea [16];
      logic [31:0] ed [16];
      int n = 0;
      bit ok = 1'b1;
      int bad = -1;
      ew[n] = 0; ea[n] = 8'h04; ed[n] = 0; n++;
      for (int i = 0; i < nin; i++) begin
         int s = (i < 4) ? i : 0;
         ew[n] = 0; ea[n] = 8'(8'h18 + 4 * s); ed[n] = a[s]; n++;
      end
      ew[n] = 0; ea[n] = 8'h00; ed[n] = 32'(cmd); n++;
      ew[n] = 1; ea[n] = 8'h04; ed[n] = 32'h8000_0000; n++;
      if (rel) begin ew[n] = 0; ea[n] = 8'h04; ed[n] = 0; n++; end
      if (wn != n) ok = 1'b0;
      else for (int i = 0; i < n; i++)
         if (ok && (wl_win[i] != ew[i] || wl_addr[i] != ea[i] || wl_data[i] != ed[i])) begin
            ok = 1'b0; bad = i;
         end
      if (bad >= 0)
         chk(ok, rq, $sformatf("write %0d addr/data", bad), {wl_addr[bad], wl_data[bad]}, {ea[bad], ed[bad]});
      else
         chk(ok, rq, "write count", longint'(wn), longint'(n));
   endtask

   function automatic logic [127:0] exp_outs(input int nout);
      logic [127:0] r = '0;
      for (int s = 0; s < 4; s++)
         if (nout > s) r[s*32 +: 32] = cfg_out[s];
      return r;
   endfunction

   initial begin
      for (int k = 0; k < 4; k++) begin a[k] = 32'h1111_0000 * (k + 1); cfg_out[k] = 32'hA000_0000 + k; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready == 1'b1, "R1", "reset ready", longint'(req_ready), 1);
      chk(done_valid == 1'b0, "R1", "reset done", longint'(done_valid), 0);
      chk(bus_req == 1'b0, "R11", "reset bus idle", longint'(bus_req), 0);

      // R2: idle check hits its limit
      cfg_busy = IDLE_N;
      run_cmd(8'h40, 1, 1);
      chk(got_code == 3'd1, "R2", "busy code", longint'(got_code), 1);
      chk(wn == 0, "R2", "writes after busy abort", longint'(wn), 0);
      chk(cmd_rd == IDLE_N, "R2", "idle reads", longint'(cmd_rd), IDLE_N);

      // R2: idle reached on the last permitted read
      cfg_busy = IDLE_N - 1; cfg_stat = 32'hF0; cfg_respond = 1'b1;
      run_cmd(8'h41, 1, 0);
      chk(got_code == 3'd0, "R2", "late idle code", longint'(got_code), 0);
      chk(cmd_rd == IDLE_N, "R2", "late idle reads", longint'(cmd_rd), IDLE_N);
      check_writes(8'h41, 1, 1'b1, "R3");
      cfg_busy = 0;

      // R3 R4 R10 R5: sweep word counts, indices past 3 fold to slot 0
      for (int nin = 0; nin <= 6; nin++) begin
         for (int k = 0; k < 4; k++) begin
            a[k] = 32'h0100_0000 * (nin + 1) + 32'(k);
            cfg_out[k] = 32'h5000_0000 + 32'h100 * nin + 32'(k);
         end
         run_cmd(8'(8'h30 + nin), nin, 6 - nin);
         chk(got_code == 3'd0, "R5", "sweep code", longint'(got_code), 0);
         check_writes(8'(8'h30 + nin), nin, 1'b1, "R4");
         chk(got_args == exp_outs(6 - nin), "R10", "result words", longint'(got_args[63:0]),
             longint'(exp_outs(6 - nin)));
      end

      // R9: status table
      for (int t = 0; t < 8; t++) begin
         logic [31:0] st;
         logic [2:0]  ec;
         case (t)
            0: begin st = 32'hF0; ec = 3'd0; end
            1: begin st = 32'hF1; ec = 3'd3; end
            2: begin st = 32'hF2; ec = 3'd4; end
            3: begin st = 32'hF3; ec = 3'd5; end
            4: begin st = 32'hF4; ec = 3'd6; end
            5: begin st = 32'hFF; ec = 3'd7; end
            6: begin st = 32'h37; ec = 3'd0; end
            default: begin st = 32'h01; ec = 3'd0; end
         endcase
         cfg_stat = st;
         run_cmd(8'h50, 2, 1);
         chk(got_code == ec, "R9", $sformatf("status 0x%0h code", st), longint'(got_code), longint'(ec));
      end

      // R8: status 0 and status above 0xFF
      cfg_stat = 32'h0;
      run_cmd(8'h51, 1, 2);
      chk(got_code == 3'd2, "R8", "status zero code", longint'(got_code), 2);
      check_writes(8'h51, 1, 1'b0, "R8");
      chk(rn == 2, "R8", "no result reads", longint'(rn), 2);
      cfg_stat = 32'h100;
      run_cmd(8'h52, 0, 2);
      chk(got_code == 3'd2, "R8", "status 0x100 code", longint'(got_code), 2);
      check_writes(8'h52, 0, 1'b0, "R8");

      // R7: no interrupt arrives
      cfg_stat = 32'hF0; cfg_respond = 1'b0;
      run_cmd(8'h53, 1, 1);
      chk(got_code == 3'd2, "R7", "irq timeout code", longint'(got_code), 2);
      chk(done_cyc - bell_cyc >= TMO && done_cyc - bell_cyc <= TMO + 8, "R7", "irq timeout delay",
          longint'(done_cyc - bell_cyc), TMO);
      check_writes(8'h53, 1, 1'b0, "R7");

      // R6: polling completion
      irq_mode_r = 1'b0; cfg_respond = 1'b1; cfg_delay = 40; cfg_stat = 32'hF3;
      run_cmd(8'h54, 1, 2);
      chk(got_code == 3'd5, "R6", "poll code", longint'(got_code), 5);
      chk(stat_rd >= 3, "R6", "poll reads", longint'(stat_rd), 3);
      chk(cmpl_irq == 1'b0, "R6", "irq line quiet", longint'(cmpl_irq), 0);
      chk(got_args == exp_outs(2), "R10", "poll result words", longint'(got_args[63:0]),
          longint'(exp_outs(2)));

      // R7 R6: polling never sees a status
      cfg_respond = 1'b0;
      run_cmd(8'h55, 0, 1);
      chk(got_code == 3'd2, "R7", "poll timeout code", longint'(got_code), 2);
      chk(done_cyc - bell_cyc >= TMO && done_cyc - bell_cyc <= TMO + 8, "R7", "poll timeout delay",
          longint'(done_cyc - bell_cyc), TMO);
      chk(stat_rd >= TMO / POLL, "R6", "poll count over timeout", longint'(stat_rd), TMO / POLL);
      check_writes(8'h55, 0, 1'b0, "R7");

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         failures++;
         $display("FAIL R1 watchdog actual=hang expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule